// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Access Arbiter

This block keeps a dynamic memory from losing data. It walks a row counter through every row of the array once per retention period. A free-running clock divider raises one refresh request per interval, and each request is added to a pending count. Every refresh cycle is address-strobe-only. The block switches the shared address multiplexer to the row counter and drives the row strobe for a fixed number of cycles. A precharge gap follows, and then the row counter advances by one. The column strobe is never touched.

Refresh and user accesses compete for the same memory, and an arbiter decides between them. A user raises a request and holds it. While the request cannot be served, the user is held off with a wait signal. When the request is served, the user sees a one-cycle grant and then owns the memory for a fixed slot that covers the access and its precharge. The normal row/column sequencing during that slot is done elsewhere. A two-bit mode input selects one of three refresh policies:

- Cycle stealing: any pending refresh goes before the user.
- Burst: the block waits until a whole period's worth of requests is pending, then refreshes every row back to back while the user is held in wait.
- Hidden: a refresh uses only cycles in which no user is requesting. If the pending count reaches an overdue threshold, refresh wins.

Top module: `dram_refresh_arbiter`

## Requirements
- R1: While reset is high, and in the cycle after it falls, the row strobe, the refresh address select and the grant are low, and the row address is 0. The wait output is low unless a user request is present.
- R2: A refresh request is generated once every DIV clock cycles. Requests are accumulated in a pending count that saturates at ROWS, so no request is lost while an access or another refresh is running.
- R3: A refresh cycle holds the address select high for RAS_CYC+PRE_CYC cycles. The row strobe is high only in the first RAS_CYC of those cycles, and only while the address select is high.
- R4: The row address advances by exactly one at the end of every refresh cycle. It wraps from ROWS-1 to 0, and it changes at no other time.
- R5: In cycle-stealing mode (mode 0), a refresh starts whenever at least one request is pending and the arbiter is idle, ahead of a user request that is present at the same time.
- R6: The wait output is high in every cycle where a user request is present and the user slot is not running. In burst mode (mode 1) it is also high throughout a refresh, whether or not a user request is present.
- R7: A granted user gets a one-cycle grant, followed by a slot of USR_CYC cycles. No refresh starts during that slot. The grant and the wait output are never high together, and the grant is never high during a refresh.
- R8: In burst mode (mode 1), refresh starts only once the pending count has reached ROWS. It then runs refresh cycles back to back, with no idle cycle between them, until the pending count is zero.
- R9: In hidden mode (mode 2), a pending refresh starts only in an idle cycle with no user request. The exception is a pending count of at least OVERDUE, in which case refresh starts even if a user request is present.
- R10: Mode 3 behaves exactly like cycle-stealing mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Refresh policy: 0 cycle stealing, 1 burst, 2 hidden, 3 as 0 |
| usr_req_i | input | 1 | User access request, held until granted |
| usr_wait_o | output | 1 | User is held off |
| usr_gnt_o | output | 1 | One-cycle grant at the start of the user slot |
| rfsh_ras_o | output | 1 | Row strobe for the refresh cycle |
| addr_sel_rfsh_o | output | 1 | Address multiplexer selects the refresh row |
| rfsh_row_o | output | ROW_W | Refresh row counter value |

## Verification
Each policy is tried with three user patterns:
- No requests at all. This shows the bare divider rate, the refresh cycle shape and the row wrap.
- Sparse requests. These arrive at arbitrary phases, so they collide with pending refreshes and with running refresh cycles.
- Back-to-back requests that keep a request present in almost every idle cycle.

The back-to-back pattern tells the policies apart. Cycle stealing still refreshes at the divider rate. Hidden refreshes only when the overdue threshold forces it. Burst waits for a full pending count and then shuts the user out for one long run. Mode 3 is run with the sparse pattern and must match cycle stealing cycle for cycle.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        MODE_STEAL  = 2'd0,
        MODE_BURST  = 2'd1,
        MODE_HIDDEN = 2'd2,
        MODE_SPARE  = 2'd3
    } rfsh_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REF  = 2'd1,
        ST_USR  = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic go_ref;
        logic go_usr;
    } arb_pick_t;

    typedef struct packed {
        logic any;
        logic full;
        logic overdue;
    } pend_flags_t;

    // Choice made in an idle cycle.
    function automatic arb_pick_t arb_pick(rfsh_mode_e m, logic req, pend_flags_t f);
        arb_pick_t p;
        p = '0;
        case (m)
            MODE_BURST:  p.go_ref = f.full;
            MODE_HIDDEN: p.go_ref = f.any && (!req || f.overdue);
            default:     p.go_ref = f.any;
        endcase
        p.go_usr = req && !p.go_ref;
        return p;
    endfunction

endpackage

// File: rtl/rfsh_timebase.sv
module rfsh_timebase #(
    parameter int DIV = 1953
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending
    import rfsh_pkg::*;
#(
    parameter int ROWS    = 512,
    parameter int OVERDUE = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        take_i,
    output pend_flags_t flags_o
);
    localparam int PEND_W = $clog2(ROWS + 1);
    localparam logic [PEND_W-1:0] FULLV = PEND_W'(ROWS);
    localparam logic [PEND_W-1:0] ODV   = PEND_W'(OVERDUE);

    logic [PEND_W-1:0] pend_q;

    assign flags_o.any     = (pend_q != '0);
    assign flags_o.full    = (pend_q == FULLV);
    assign flags_o.overdue = (pend_q >= ODV);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            case ({tick_i, take_i})
                2'b10:   if (pend_q != FULLV) pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    output logic [ROW_W-1:0] row_o
);
    always_ff @(posedge clk) begin
        if (rst)         row_o <= '0;
        else if (step_i) row_o <= row_o + 1'b1;
    end
endmodule

// File: rtl/rfsh_arb_fsm.sv
module rfsh_arb_fsm
    import rfsh_pkg::*;
#(
    parameter int RAS_CYC = 30,
    parameter int PRE_CYC = 8,
    parameter int USR_CYC = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  rfsh_mode_e  mode_i,
    input  logic        req_i,
    input  pend_flags_t flags_i,
    output logic        take_o,
    output logic        step_o,
    output logic        ras_o,
    output logic        sel_o,
    output logic        gnt_o,
    output logic        wait_o
);
    localparam int REF_CYC = RAS_CYC + PRE_CYC;
    localparam int MAXC    = (REF_CYC > USR_CYC) ? REF_CYC : USR_CYC;
    localparam int CYC_W   = $clog2(MAXC + 1);
    localparam logic [CYC_W-1:0] REF_LAST = CYC_W'(REF_CYC - 1);
    localparam logic [CYC_W-1:0] USR_LAST = CYC_W'(USR_CYC - 1);
    localparam logic [CYC_W-1:0] RAS_END  = CYC_W'(RAS_CYC);

    arb_state_e       st_q;
    logic [CYC_W-1:0] cnt_q;
    arb_pick_t        pick;
    logic             ref_last, usr_last, chain;

    assign pick     = arb_pick(mode_i, req_i, flags_i);
    assign ref_last = (st_q == ST_REF) && (cnt_q == REF_LAST);
    assign usr_last = (st_q == ST_USR) && (cnt_q == USR_LAST);
    assign chain    = ref_last && (mode_i == MODE_BURST) && flags_i.any;

    assign take_o = ((st_q == ST_IDLE) && pick.go_ref) || chain;
    assign step_o = ref_last;
    assign sel_o  = (st_q == ST_REF);
    assign ras_o  = (st_q == ST_REF) && (cnt_q < RAS_END);
    assign gnt_o  = (st_q == ST_USR) && (cnt_q == '0);
    assign wait_o = (req_i && (st_q != ST_USR)) ||
                    ((st_q == ST_REF) && (mode_i == MODE_BURST));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (pick.go_ref)      st_q <= ST_REF;
                    else if (pick.go_usr) st_q <= ST_USR;
                end
                ST_REF: begin
                    if (ref_last) begin
                        cnt_q <= '0;
                        st_q  <= chain ? ST_REF : ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_USR: begin
                    if (usr_last) begin
                        cnt_q <= '0;
                        st_q  <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    st_q  <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_arbiter.sv
module dram_refresh_arbiter
    import rfsh_pkg::*;
#(
    parameter int ROW_W   = 9,
    parameter int DIV     = 1953,
    parameter int RAS_CYC = 30,
    parameter int PRE_CYC = 8,
    parameter int USR_CYC = 12,
    parameter int OVERDUE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic             usr_req_i,
    output logic             usr_wait_o,
    output logic             usr_gnt_o,
    output logic             rfsh_ras_o,
    output logic             addr_sel_rfsh_o,
    output logic [ROW_W-1:0] rfsh_row_o
);
    localparam int ROWS = 1 << ROW_W;

    logic        tick, take, step;
    pend_flags_t flags;
    rfsh_mode_e  mode;

    assign mode = rfsh_mode_e'(mode_i);

    rfsh_timebase #(.DIV(DIV)) u_tb (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    rfsh_pending #(.ROWS(ROWS), .OVERDUE(OVERDUE)) u_pend (
        .clk(clk), .rst(rst), .tick_i(tick), .take_i(take), .flags_o(flags)
    );

    rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst(rst), .step_i(step), .row_o(rfsh_row_o)
    );

    rfsh_arb_fsm #(.RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC), .USR_CYC(USR_CYC)) u_fsm (
        .clk(clk), .rst(rst), .mode_i(mode), .req_i(usr_req_i), .flags_i(flags),
        .take_o(take), .step_o(step), .ras_o(rfsh_ras_o), .sel_o(addr_sel_rfsh_o),
        .gnt_o(usr_gnt_o), .wait_o(usr_wait_o)
    );
endmodule

// File: rtl/rfsh_chk.sv
module rfsh_chk #(
    parameter int ROW_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             usr_wait_o,
    input logic             usr_gnt_o,
    input logic             rfsh_ras_o,
    input logic             addr_sel_rfsh_o,
    input logic [ROW_W-1:0] rfsh_row_o
);
    p_ras_needs_sel_r3: assert property (@(posedge clk) disable iff (rst)
        rfsh_ras_o |-> addr_sel_rfsh_o);

    p_ras_leads_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_sel_rfsh_o) |-> rfsh_ras_o);

    p_row_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        (rfsh_row_o != $past(rfsh_row_o)) |-> (rfsh_row_o == $past(rfsh_row_o) + 1'b1));

    p_gnt_not_in_ref_r7: assert property (@(posedge clk) disable iff (rst)
        usr_gnt_o |-> !addr_sel_rfsh_o);

    p_gnt_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        usr_gnt_o |=> !usr_gnt_o);

    p_gnt_clears_wait_r6: assert property (@(posedge clk) disable iff (rst)
        usr_gnt_o |-> !usr_wait_o);
endmodule

bind dram_refresh_arbiter rfsh_chk #(.ROW_W(ROW_W)) u_rfsh_chk (
    .clk(clk), .rst(rst), .usr_wait_o(usr_wait_o), .usr_gnt_o(usr_gnt_o),
    .rfsh_ras_o(rfsh_ras_o), .addr_sel_rfsh_o(addr_sel_rfsh_o), .rfsh_row_o(rfsh_row_o)
);

// File: tb/tb_dram_refresh_arbiter.sv
`timescale 1ns/1ps
module tb_dram_refresh_arbiter;
    localparam int ROW_W = 4;
    localparam int ROWS  = 1 << ROW_W;
    localparam int DIV   = 40;
    localparam int RASC  = 3;
    localparam int PREC  = 2;
    localparam int USRC  = 4;
    localparam int ODUE  = 3;
    localparam int REFC  = RASC + PREC;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       mode = 2'd0;
    logic             req = 1'b0;
    logic             wait_o, gnt_o, ras_o, sel_o;
    logic [ROW_W-1:0] row_o;

    int compared = 0;
    int mismatched = 0;
    int pattern = 0;      // 0 none, 1 sparse, 2 back-to-back
    int sparse_gap = 0;
    string phase = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    dram_refresh_arbiter #(.ROW_W(ROW_W), .DIV(DIV), .RAS_CYC(RASC), .PRE_CYC(PREC),
                           .USR_CYC(USRC), .OVERDUE(ODUE)) dut (
        .clk(clk), .rst(rst), .mode_i(mode), .usr_req_i(req), .usr_wait_o(wait_o),
        .usr_gnt_o(gnt_o), .rfsh_ras_o(ras_o), .addr_sel_rfsh_o(sel_o), .rfsh_row_o(row_o));

    // Behavioural reference: states 0 idle, 1 refresh, 2 user slot.
    int m_div, m_pend, m_state, m_cnt, m_row;
    always @(posedge clk) begin
        bit tick, take, go_ref;
        if (rst) begin
            m_div = 0; m_pend = 0; m_state = 0; m_cnt = 0; m_row = 0;
        end else begin
            tick = (m_div == DIV - 1);
            m_div = tick ? 0 : m_div + 1;
            take = 0;
            case (m_state)
                0: begin
                    if (mode == 2'd1)      go_ref = (m_pend == ROWS);
                    else if (mode == 2'd2) go_ref = (m_pend > 0) && (!req || m_pend >= ODUE);
                    else                   go_ref = (m_pend > 0);
                    m_cnt = 0;
                    if (go_ref) begin take = 1; m_state = 1; end
                    else if (req) m_state = 2;
                end
                1: begin
                    if (m_cnt == REFC - 1) begin
                        m_row = (m_row + 1) % ROWS;
                        m_cnt = 0;
                        if (mode == 2'd1 && m_pend > 0) take = 1;
                        else m_state = 0;
                    end else m_cnt++;
                end
                default: begin
                    if (m_cnt == USRC - 1) begin m_cnt = 0; m_state = 0; end
                    else m_cnt++;
                end
            endcase
            if (tick && !take) m_pend = (m_pend < ROWS) ? m_pend + 1 : ROWS;
            else if (!tick && take) m_pend = m_pend - 1;
        end
    end

    task automatic cmp(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s (%s) at %0t: actual %0d expected %0d", tag, phase, $time, act, exp);
        end
    endtask

    task automatic check_dir(string tag, bit ok, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Directed observations of the DUT outputs.
    int run_len = 0, max_run = 0, ref_starts = 0, wraps = 0;
    bit prev_sel = 0;
    int prev_row = 0;

    task automatic step_cycle();
        bit m_ras, m_sel, m_gnt, m_wait;
        @(negedge clk);
        m_sel  = (m_state == 1);
        m_ras  = m_sel && (m_cnt < RASC);
        m_gnt  = (m_state == 2) && (m_cnt == 0);
        m_wait = (req && m_state != 2) || (m_sel && mode == 2'd1);
        cmp("R3 ras", ras_o, m_ras);
        cmp("R3 sel", sel_o, m_sel);
        cmp("R4 row", row_o, m_row);
        cmp("R6 wait", wait_o, m_wait);
        cmp("R7 gnt", gnt_o, m_gnt);
        if (sel_o) run_len++; else run_len = 0;
        if (run_len > max_run) max_run = run_len;
        if (sel_o && !prev_sel) ref_starts++;
        if (prev_row == ROWS - 1 && row_o == 0) wraps++;
        prev_sel = sel_o;
        prev_row = row_o;
        // user agent
        if (pattern == 2) req = !m_gnt;
        else if (pattern == 1) begin
            if (m_gnt) req = 0;
            else if (!req) begin
                sparse_gap++;
                if (sparse_gap >= 11) begin req = 1; sparse_gap = 0; end
            end
        end else if (m_gnt) req = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step_cycle();
    endtask

    initial begin
        // R1: reset state
        rst = 1'b1;
        run(4);
        check_dir("R1 reset sel/ras/gnt", !sel_o && !ras_o && !gnt_o && !wait_o, sel_o, 0);
        @(negedge clk) rst = 1'b0;
        check_dir("R1 reset row", row_o == 0, row_o, 0);

        // R2, R3, R4: cycle stealing, no user
        phase = "R2";
        pattern = 0; mode = 2'd0;
        run(DIV * ROWS + 200);
        check_dir("R4 row wrap seen", wraps >= 1, wraps, 1);
        check_dir("R2 refresh rate", ref_starts >= ROWS, ref_starts, ROWS);

        // R5: cycle stealing with sparse and back-to-back users
        phase = "R5";
        pattern = 1; run(900);
        pattern = 2; ref_starts = 0; run(800);
        check_dir("R5 refresh keeps divider rate", ref_starts >= 800 / DIV - 1, ref_starts, 800 / DIV - 1);

        // R9: hidden mode, back-to-back then sparse then idle
        phase = "R9";
        pattern = 0; run(60);
        mode = 2'd2; pattern = 2; ref_starts = 0;
        run(1200);
        check_dir("R9 overdue refresh served", ref_starts > 0, ref_starts, 1);
        pattern = 1; run(800);
        pattern = 0; run(200);

        // R8: burst mode, wait for full pending count then a back-to-back run
        phase = "R8";
        mode = 2'd1; max_run = 0;
        pattern = 1; run(DIV * ROWS + 300);
        check_dir("R8 burst run length", max_run >= ROWS * REFC, max_run, ROWS * REFC);
        pattern = 2; run(DIV * ROWS + 300);

        // R10: mode 3 with sparse users
        phase = "R10";
        pattern = 0; run(100);
        mode = 2'd3; pattern = 1; run(1500);
        pattern = 0; run(50);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired at %0t: actual 0 expected 1", $time);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule